// File: doc/BRIEF.md
# Scaled Index Address Generator

This block forms a 32-bit effective address for a load, a store or an address-only operation. The address is the sum of three terms. The first is a base register value. The second is an index register value shifted left by 0 to 3 bit positions. The third is a signed displacement, taken either as a full 32-bit word or as a sign-extended byte. Enables turn the index term and the displacement term on or off, so one adder tree covers four forms: base plus displacement, base plus index, base plus scaled index, and base plus scaled index plus displacement.

An address-only request uses the same address computation. The address goes to a result port with a write-back strobe, and no memory request is raised. A memory request raises a request strobe and carries the address. It also raises an informational misalignment flag when the address is not a multiple of the access size. The flag does not stop the access.

The parameter `REG_OUT` selects the output timing. With `REG_OUT=1`, the default, outputs appear one clock after the inputs. With `REG_OUT=0`, the block is purely combinational.

Top module: `addr_gen_top`

## Requirements
- R1: With `REG_OUT=1`, `ea_o` equals `base_i + index_term + disp_term` modulo 2^32, one clock after the inputs are presented. Carries out of bit 31 are dropped.
- R2: `scale_i` codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R3: When `index_en_i` is 0, the index term is zero, whatever the values of `index_i` and `scale_i`.
- R4: When `disp_wide_i` is 0, only `disp_i[7:0]` is used, sign-extended to 32 bits, and `disp_i[31:8]` has no effect. When `disp_wide_i` is 1, all 32 bits of `disp_i` are added.
- R5: When `disp_en_i` is 0, the displacement term is zero, whatever the values of `disp_i` and `disp_wide_i`.
- R6: For a valid request with `addr_only_i`=1, `result_o` carries the address, `wb_o` is 1, `mem_req_o` is 0 and `misalign_o` is 0.
- R7: For a valid request with `addr_only_i`=0, `mem_req_o` is 1, `wb_o` is 0 and `result_o` is 0. When `valid_i` is 0, both strobes are 0.
- R8: For a memory request, `misalign_o` depends on `size_i`. Code 0 (byte) never sets it. Code 1 (half-word) sets it when bit 0 of the address is 1. Codes 2 and 3 (word) set it when bits 1:0 of the address are not both 0.
- R9: A synchronous active-low reset clears every output to 0 while `rst_n` is low, even with `valid_i` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Request present |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| index_en_i | input | 1 | Include the scaled index term |
| scale_i | input | 2 | Index shift amount, 0 to 3 |
| disp_i | input | 32 | Displacement immediate |
| disp_wide_i | input | 1 | 1: 32-bit displacement, 0: sign-extended low byte |
| disp_en_i | input | 1 | Include the displacement term |
| addr_only_i | input | 1 | Return the address as the result, with no memory access |
| size_i | input | 2 | Access size code: 0 byte, 1 half-word, 2 and 3 word |
| ea_o | output | 32 | Effective address |
| mem_req_o | output | 1 | Memory access request |
| wb_o | output | 1 | Address-only result valid |
| result_o | output | 32 | Address result for an address-only request |
| misalign_o | output | 1 | Informational misalignment flag |

## Verification
The bench targets the sign boundary of the narrow displacement. A byte of 0x80 must subtract 128, and if the extension is wrong the address lands 256 bytes too high, or high bits of the immediate leak into the sum. It checks that the index term disappears when its enable is off even with scale 3 and a large index, where a design that only gates the shift would add the index anyway. It runs a sum that wraps past 2^32 to a small value, and confirms that an address-only request never raises a memory strobe or a misalignment flag. It also confirms that size code 3 is checked as a word, where a flawed design would flag the wrong addresses.

// File: rtl/agu_pkg.sv
// Package: shared widths and the access-size encoding for the address generator.
// Assumes: byte-addressed memory, access sizes of 1, 2 or 4 bytes.
package agu_pkg;
    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned SCALE_W = 2;
    localparam int unsigned SIZE_W  = 2;

    typedef enum logic [SIZE_W-1:0] {
        ACC_BYTE  = 2'd0,
        ACC_HALF  = 2'd1,
        ACC_WORD  = 2'd2,
        ACC_WORD2 = 2'd3
    } acc_size_e;
endpackage

// File: rtl/agu_disp_ext.sv
// Module: displacement term former.
// Selects a sign-extended narrow field or the full-width immediate and zeroes
// the term when the displacement is disabled.
// Assumes: NARROW_W < AW.
module agu_disp_ext #(
    parameter int unsigned AW       = 32,
    parameter int unsigned NARROW_W = 8
) (
    input  logic [AW-1:0] disp_raw,
    input  logic          wide,
    input  logic          en,
    output logic [AW-1:0] term
);
    localparam int unsigned PAD_W = AW - NARROW_W;

    logic [AW-1:0] narrow_ext;

    // Sign-extend the low field to the full address width.
    always_comb narrow_ext = {{PAD_W{disp_raw[NARROW_W-1]}}, disp_raw[NARROW_W-1:0]};

    // Pick the encoding and apply the enable.
    always_comb begin
        if (!en)       term = '0;
        else if (wide) term = disp_raw;
        else           term = narrow_ext;
    end
endmodule

// File: rtl/agu_index_scale.sv
// Module: scaled index term.
// Builds every shifted copy of the index and selects one with the scale code.
// Forces the term to zero when the index is disabled.
// Assumes: the scale code spans all 2**SW shift amounts.
module agu_index_scale #(
    parameter int unsigned AW = 32,
    parameter int unsigned SW = 2
) (
    input  logic [AW-1:0] index,
    input  logic [SW-1:0] scale,
    input  logic          en,
    output logic [AW-1:0] term
);
    localparam int unsigned NSHIFT = 1 << SW;

    logic [AW-1:0] shifted [NSHIFT];

    for (genvar g = 0; g < NSHIFT; g++) begin : g_shift
        // One fixed left shift per scale code.
        always_comb shifted[g] = index << g;
    end

    // Select the shifted copy and gate it with the enable.
    always_comb term = en ? shifted[scale] : '0;
endmodule

// File: rtl/agu_align_chk.sv
// Module: alignment checker.
// Flags an address whose low bits are not zero for the given access size.
// Assumes: size code 3 behaves as a word access.
module agu_align_chk
    import agu_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0]     ea,
    input  logic [SIZE_W-1:0] size,
    input  logic              check_en,
    output logic              misalign
);
    logic [1:0] low_mask;

    // Map the size code to the mask of low address bits that must be zero.
    always_comb begin
        case (acc_size_e'(size))
            ACC_BYTE: low_mask = 2'b00;
            ACC_HALF: low_mask = 2'b01;
            default:  low_mask = 2'b11;
        endcase
    end

    // Raise the flag only when a memory access is being issued.
    always_comb misalign = check_en && ((ea[1:0] & low_mask) != 2'b00);
endmodule

// File: rtl/addr_gen_top.sv
// Module: scaled index address generator, top level.
// Adds base, scaled index and displacement modulo 2**AW. Routes the address to a
// memory request or to an address-only result, and flags misalignment.
// Assumes: decode has already chosen the enables; REG_OUT=1 adds one output register.
module addr_gen_top
    import agu_pkg::*;
#(
    parameter int unsigned AW      = ADDR_W,
    parameter int unsigned SW      = SCALE_W,
    parameter int unsigned DISP_NW = 8,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [AW-1:0]     base_i,
    input  logic [AW-1:0]     index_i,
    input  logic              index_en_i,
    input  logic [SW-1:0]     scale_i,
    input  logic [AW-1:0]     disp_i,
    input  logic              disp_wide_i,
    input  logic              disp_en_i,
    input  logic              addr_only_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [AW-1:0]     ea_o,
    output logic              mem_req_o,
    output logic              wb_o,
    output logic [AW-1:0]     result_o,
    output logic              misalign_o
);
    logic [AW-1:0] index_term;
    logic [AW-1:0] disp_term;
    logic [AW-1:0] ea_c;
    logic [AW-1:0] result_c;
    logic          mem_req_c;
    logic          wb_c;
    logic          misalign_c;

    agu_index_scale #(.AW(AW), .SW(SW)) u_idx (
        .index (index_i),
        .scale (scale_i),
        .en    (index_en_i),
        .term  (index_term)
    );

    agu_disp_ext #(.AW(AW), .NARROW_W(DISP_NW)) u_disp (
        .disp_raw (disp_i),
        .wide     (disp_wide_i),
        .en       (disp_en_i),
        .term     (disp_term)
    );

    // Three-operand sum; the carry out of the top bit is dropped.
    always_comb ea_c = base_i + index_term + disp_term;

    // Steer the request to the memory path or to the address-only result path.
    always_comb begin
        mem_req_c = valid_i && !addr_only_i;
        wb_c      = valid_i && addr_only_i;
        result_c  = wb_c ? ea_c : '0;
    end

    agu_align_chk #(.AW(AW)) u_align (
        .ea       (ea_c),
        .size     (size_i),
        .check_en (mem_req_c),
        .misalign (misalign_c)
    );

    if (REG_OUT) begin : g_reg
        // Output register with synchronous active-low clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ea_o       <= '0;
                mem_req_o  <= 1'b0;
                wb_o       <= 1'b0;
                result_o   <= '0;
                misalign_o <= 1'b0;
            end else begin
                ea_o       <= ea_c;
                mem_req_o  <= mem_req_c;
                wb_o       <= wb_c;
                result_o   <= result_c;
                misalign_o <= misalign_c;
            end
        end

        // R1: registered address matches the previous cycle's operands.
        a_r1_registered_sum: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> ea_o == $past(base_i + index_term + disp_term));
        // R9: the cycle after reset is held, the outputs are cleared.
        a_r9_reset_clears: assert property (@(posedge clk)
            $past(rst_n) == 1'b0 && $past(valid_i) |-> !mem_req_o && !wb_o && ea_o == '0);
    end else begin : g_comb
        // Pass-through when no output register is wanted.
        always_comb begin
            ea_o       = ea_c;
            mem_req_o  = mem_req_c;
            wb_o       = wb_c;
            result_o   = result_c;
            misalign_o = misalign_c;
        end
    end

    // R3: a disabled index contributes nothing.
    a_r3_index_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !index_en_i |-> index_term == '0);
    // R2: the largest scale leaves the low three bits of the index term clear.
    a_r2_scale8_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        index_en_i && scale_i == 2'd3 |-> index_term[2:0] == 3'b000);
    // R4: a narrow displacement fills the upper bits with its sign bit.
    a_r4_narrow_sign: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en_i && !disp_wide_i |-> disp_term[AW-1:DISP_NW] == {(AW-DISP_NW){disp_i[DISP_NW-1]}});
    // R5: a disabled displacement contributes nothing.
    a_r5_disp_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en_i |-> disp_term == '0);
    // R6 and R7: the two strobes never assert together.
    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req_o, wb_o}));
    // R8: the misalignment flag only accompanies a memory request.
    a_r8_flag_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> mem_req_o);
endmodule

// File: tb/addr_gen_top_tb.sv
// Bench for addr_gen_top with REG_OUT=1: a table walk, then directed and random checks.
module addr_gen_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] idx;
        logic        ien;
        logic [1:0]  sc;
        logic [31:0] disp;
        logic        dwide;
        logic        den;
        logic        aonly;
        logic [1:0]  size;
        logic [31:0] exp_ea;
        logic        exp_mis;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_1000, 32'h0, 1'b0, 2'd0, 32'h10,        1'b0, 1'b1, 1'b0, 2'd2, 32'h0000_1010, 1'b0},
        '{32'h0000_1000, 32'h3, 1'b1, 2'd0, 32'h0,         1'b0, 1'b0, 1'b0, 2'd1, 32'h0000_1003, 1'b1},
        '{32'h0000_1000, 32'h3, 1'b1, 2'd1, 32'h0,         1'b0, 1'b0, 1'b0, 2'd2, 32'h0000_1006, 1'b1},
        '{32'h0000_1000, 32'h3, 1'b1, 2'd2, 32'h0,         1'b0, 1'b0, 1'b0, 2'd2, 32'h0000_100C, 1'b0},
        '{32'h0000_1000, 32'h3, 1'b1, 2'd3, 32'hFF,        1'b0, 1'b1, 1'b0, 2'd0, 32'h0000_1017, 1'b0},
        '{32'h0000_0200, 32'h0, 1'b0, 2'd3, 32'h1234_5680, 1'b0, 1'b1, 1'b0, 2'd2, 32'h0000_0180, 1'b0},
        '{32'h0000_0200, 32'h0, 1'b0, 2'd0, 32'h1234_5680, 1'b1, 1'b1, 1'b0, 2'd1, 32'h1234_5880, 1'b0},
        '{32'hFFFF_FFF0, 32'h4, 1'b1, 2'd2, 32'h5,         1'b0, 1'b1, 1'b1, 2'd2, 32'h0000_0005, 1'b0},
        '{32'h0000_0040, 32'hFFFF, 1'b0, 2'd3, 32'h0,      1'b0, 1'b0, 1'b0, 2'd2, 32'h0000_0040, 1'b0},
        '{32'h0000_0041, 32'h0, 1'b0, 2'd0, 32'h7F,        1'b1, 1'b0, 1'b0, 2'd3, 32'h0000_0041, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] base_i = '0, index_i = '0, disp_i = '0;
    logic        index_en_i = 1'b0, disp_wide_i = 1'b0, disp_en_i = 1'b0, addr_only_i = 1'b0;
    logic [1:0]  scale_i = '0, size_i = '0;
    logic [31:0] ea_o, result_o;
    logic        mem_req_o, wb_o, misalign_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_gen_top dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .base_i(base_i), .index_i(index_i),
        .index_en_i(index_en_i), .scale_i(scale_i), .disp_i(disp_i), .disp_wide_i(disp_wide_i),
        .disp_en_i(disp_en_i), .addr_only_i(addr_only_i), .size_i(size_i), .ea_o(ea_o),
        .mem_req_o(mem_req_o), .wb_o(wb_o), .result_o(result_o), .misalign_o(misalign_o)
    );

    // Independent model of the requirements.
    function automatic logic [31:0] model_ea(logic [31:0] b, logic [31:0] x, logic ie, logic [1:0] s,
                                             logic [31:0] d, logic dw, logic de);
        logic [31:0] f, xt, dt;
        case (s)
            2'd0: f = 32'd1;
            2'd1: f = 32'd2;
            2'd2: f = 32'd4;
            default: f = 32'd8;
        endcase
        xt = ie ? x * f : 32'd0;
        if (!de)     dt = 32'd0;
        else if (dw) dt = d;
        else         dt = 32'($signed(d[7:0]));
        return b + xt + dt;
    endfunction

    function automatic logic model_mis(logic [31:0] a, logic [1:0] sz, logic memop);
        if (!memop) return 1'b0;
        if (sz == 2'd0) return 1'b0;
        if (sz == 2'd1) return a[0];
        return a[1:0] != 2'b00;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(logic v, logic [31:0] b, logic [31:0] x, logic ie, logic [1:0] s,
                         logic [31:0] d, logic dw, logic de, logic ao, logic [1:0] sz);
        @(negedge clk);
        valid_i = v; base_i = b; index_i = x; index_en_i = ie; scale_i = s;
        disp_i = d; disp_wide_i = dw; disp_en_i = de; addr_only_i = ao; size_i = sz;
        @(negedge clk);
    endtask

    task automatic check_all(string req, logic [31:0] ea, logic ao, logic mis);
        check(req, "ea", ea_o, ea);
        check(ao ? "R6" : "R7", "mem_req", {31'd0, mem_req_o}, {31'd0, !ao});
        check(ao ? "R6" : "R7", "wb", {31'd0, wb_o}, {31'd0, ao});
        check(ao ? "R6" : "R7", "result", result_o, ao ? ea : 32'd0);
        check("R8", "misalign", {31'd0, misalign_o}, {31'd0, mis});
    endtask

    initial begin
        // R9: reset holds outputs at zero while a request is presented.
        valid_i = 1'b1; base_i = 32'h1234_5678; size_i = 2'd2;
        repeat (3) @(negedge clk);
        check("R9", "ea in reset", ea_o, 32'd0);
        check("R9", "strobes in reset", {30'd0, mem_req_o, wb_o}, 32'd0);
        check("R9", "result in reset", result_o, 32'd0);
        rst_n = 1'b1;

        // Table walk: R1 to R5 and R8 through fixed vectors.
        for (int i = 0; i < NVEC; i++) begin
            drive(1'b1, VECS[i].base, VECS[i].idx, VECS[i].ien, VECS[i].sc, VECS[i].disp,
                  VECS[i].dwide, VECS[i].den, VECS[i].aonly, VECS[i].size);
            check_all("R1", VECS[i].exp_ea, VECS[i].aonly, VECS[i].exp_mis);
        end

        // R7: no request means no strobes.
        drive(1'b0, 32'h3, 32'h0, 1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0, 2'd2);
        check("R7", "idle strobes", {30'd0, mem_req_o, wb_o}, 32'd0);
        check("R8", "idle misalign", {31'd0, misalign_o}, 32'd0);

        // R6: an address-only request at an odd address raises no flag.
        drive(1'b1, 32'h0000_0103, 32'h0, 1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b1, 2'd2);
        check_all("R6", 32'h0000_0103, 1'b1, 1'b0);

        // R5: a disabled wide displacement has no effect.
        drive(1'b1, 32'h0000_0800, 32'h0, 1'b0, 2'd0, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0, 2'd0);
        check("R5", "disp off", ea_o, 32'h0000_0800);

        // R2 and R4: random operands in every form, against the model.
        for (int n = 0; n < 400; n++) begin
            logic [31:0] b, x, d;
            logic ie, dw, de, ao;
            logic [1:0] s, sz;
            logic [31:0] e;
            b = $urandom; x = $urandom; d = $urandom;
            ie = 1'($urandom); dw = 1'($urandom); de = 1'($urandom); ao = 1'($urandom);
            s = 2'($urandom); sz = 2'($urandom);
            e = model_ea(b, x, ie, s, d, dw, de);
            drive(1'b1, b, x, ie, s, d, dw, de, ao, sz);
            check_all(ie ? "R2" : "R4", e, ao, model_mis(e, sz, !ao));
        end

        // R9: reset asserted mid-stream clears the registered outputs.
        @(negedge clk);
        rst_n = 1'b0; valid_i = 1'b1; addr_only_i = 1'b1; base_i = 32'h44;
        @(negedge clk);
        check("R9", "ea after reset", ea_o, 32'd0);
        check("R9", "wb after reset", {31'd0, wb_o}, 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule